// File: doc/BRIEF.md
# SDLC Frame Transmitter with NRZI Line Coding

This block turns a stream of payload bytes into one complete synchronous data-link frame on a single serial line. A source offers bytes over a valid/ready handshake and marks the final byte with a last flag. The block leads off with a run of raw synchronisation bytes, then sends an opening flag, the payload, a 16-bit frame check sequence and a closing flag. Payload and check sequence pass through zero-bit insertion, and everything after the sync bytes is NRZI coded.

A bit-clock enable paces the block: one line bit per enabled cycle, and the line never moves on other cycles. The line rests high between frames. A one-cycle done pulse marks the end of each frame. The source must present each payload byte by the time the block asks for it. If a requested byte is missing, the block waits and the line holds its level.

Top module: `sdlc_nrzi_tx`

## Requirements
- R1: After reset and between frames, `line_out` is 1, `done` is 0 and `in_ready` is 0.
- R2: A frame starts on the first `bit_en` cycle on which `in_valid` is high while the block is idle. It begins with SYNC_BYTES copies of SYNC_PATTERN (default two bytes of 0x55), sent most significant bit first and driven straight onto the line, with no NRZI coding and no zero insertion.
- R3: An opening flag and a closing flag of value 0x7E frame the data. Each is sent least significant bit first, NRZI coded, and never has zeros inserted.
- R4: Payload bytes go out least significant bit first. `in_ready` is high exactly on the `bit_en` cycle that sends bit 0 of a payload byte. The byte accepted with `in_last` high is the final payload byte.
- R5: In the payload and check sequence, a 0 is inserted after every five consecutive 1 bits. The run count is cleared by any 0, including an inserted one. The count starts from zero at the first payload bit, and an insertion can fall before the next byte, before the check sequence or before the closing flag.
- R6: NRZI coding: a 0 bit (inserted zeros included) toggles the line and a 1 bit holds it. Coding continues from the level left by the last sync bit.
- R7: The check sequence is the complement of a reflected CRC-16. It uses polynomial 0x8408 and start value 0xFFFF, and is computed over the payload bits in the order they are sent. It is sent low byte first, each byte least significant bit first. Running the same CRC over payload plus check sequence leaves 0xF0B8.
- R8: `in_ready` is 0 on every cycle that sends a sync bit, a flag bit, an inserted zero or a check-sequence bit.
- R9: `done` is high for exactly one cycle: the cycle after the `bit_en` cycle that follows the last closing-flag bit. The line is 1 from that point.
- R10: `line_out` changes only in the cycle after a cycle with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the final payload byte |
| in_ready | output | 1 | Block accepts the offered byte in this cycle |
| line_out | output | 1 | Serial line, NRZI coded after the sync bytes |
| done | output | 1 | One-cycle pulse at end of frame |

## Verification
A zero insertion and a payload byte fetch can be due on the same bit tick. This happens when a run of five ones ends exactly on a byte boundary. The block must then send the inserted zero first, keep `in_ready` low, and fetch the next byte one tick later. The bench provokes this with the payload 0xF8 followed by 0x0F, and with runs of 0xFF bytes. The scoreboard tags each expected bit as a byte start, an inserted zero or a check-sequence bit, and compares both the line level and `in_ready` on every tick. A fetch taken one tick early, or a lost inserted zero, shows up as a level or ready mismatch.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SYNC  = 3'd1,
      PH_OPEN  = 3'd2,
      PH_DATA  = 3'd3,
      PH_FCS   = 3'd4,
      PH_CLOSE = 3'd5
   } tx_phase_e;

   // Bit reversal turns an MSB-first byte into one that an LSB-first shifter emits correctly
   function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] v);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
      return r;
   endfunction

endpackage

// File: rtl/sdlc_fcs16.sv
module sdlc_fcs16 #(
   parameter logic [15:0] POLY = 16'h8408,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        step,
   input  logic        bit_in,
   output logic [15:0] fcs_word
);
   logic [15:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         crc_q <= INIT;
      end else if (step) begin
         crc_q <= (crc_q >> 1) ^ (((crc_q[0] ^ bit_in) == 1'b1) ? POLY : 16'h0000);
      end
   end

   assign fcs_word = ~crc_q;

   AST_CRC_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (fcs_word == ~INIT)) else $error("crc clear"); // R7
endmodule

// File: rtl/sdlc_zero_insert.sv
module sdlc_zero_insert #(
   parameter int RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic count_en,
   input  logic bit_in,
   output logic insert_due
);
   localparam int OW = $clog2(RUN + 1);
   logic [OW-1:0] ones_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (adv) begin
         ones_q <= (count_en && bit_in) ? ones_q + OW'(1) : '0;
      end
   end

   assign insert_due = (ones_q == OW'(RUN));

   AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= OW'(RUN)) else $error("run count over limit"); // R5
   AST_ZERO_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !bit_in) |=> (ones_q == '0)) else $error("zero did not clear run"); // R5
endmodule

// File: rtl/sdlc_line_coder.sv
module sdlc_line_coder #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic raw_mode,
   input  logic bit_in,
   input  logic go_idle,
   output logic line
);
   always_ff @(posedge clk) begin
      if (!rst_n || go_idle) begin
         line <= IDLE_LEVEL;
      end else if (adv) begin
         if (raw_mode)    line <= bit_in;
         else if (!bit_in) line <= ~line;
      end
   end

   AST_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !raw_mode && bit_in && !go_idle) |=> $stable(line)) else $error("one moved line"); // R6
   AST_ZERO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !raw_mode && !bit_in && !go_idle) |=> (line != $past(line))) else $error("zero kept line"); // R6
endmodule

// File: rtl/sdlc_nrzi_tx.sv
module sdlc_nrzi_tx
   import sdlc_tx_pkg::*;
#(
   parameter int          SYNC_BYTES   = 2,
   parameter logic [7:0]  SYNC_PATTERN = 8'h55,
   parameter logic [7:0]  FLAG_PATTERN = 8'h7E,
   parameter int          STUFF_RUN    = 5,
   parameter logic [15:0] CRC_POLY     = 16'h8408,
   parameter logic [15:0] CRC_INIT     = 16'hFFFF,
   parameter logic        IDLE_LEVEL   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   output logic       line_out,
   output logic       done
);
   localparam int REM_W = $clog2(BYTE_W);
   localparam int SC_W  = $clog2(SYNC_BYTES + 2);
   localparam logic [BYTE_W-1:0] SYNC_LSB_FIRST = rev_byte(SYNC_PATTERN);

   // Elaboration-time parameter checks
   if (STUFF_RUN < 1 || STUFF_RUN > 15) begin : g_bad_run
      $error("STUFF_RUN must lie in 1..15");
   end
   if (SYNC_BYTES < 0 || SYNC_BYTES > 64) begin : g_bad_sync
      $error("SYNC_BYTES must lie in 0..64");
   end

   tx_phase_e          phase_q, ph_n;
   logic [BYTE_W-1:0]  sh_q, sh_n;
   logic [REM_W-1:0]   rem_q, rem_n;
   logic               last_q, last_n;
   logic               fcs_hi_q, fcs_hi_n;
   logic               done_n;

   logic               need, stuff_due, stuff_now, want_byte;
   logic               adv, bit_o, go_idle, count_en, raw_mode;
   logic               crc_step, crc_clear;
   logic               sync_first, sync_step, sync_more;
   logic               ld;
   logic [BYTE_W-1:0]  ld_byte;
   logic [15:0]        fcs_word;

   // Sync byte counter: present only when sync bytes are configured
   if (SYNC_BYTES > 0) begin : g_sync
      logic [SC_W-1:0] sync_cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          sync_cnt_q <= '0;
         else if (sync_first) sync_cnt_q <= SC_W'(1);
         else if (sync_step)  sync_cnt_q <= sync_cnt_q + SC_W'(1);
      end
      assign sync_more = (sync_cnt_q < SC_W'(SYNC_BYTES));
   end else begin : g_no_sync
      assign sync_more = 1'b0;
   end

   assign need      = (rem_q == '0);
   assign stuff_now = bit_en && stuff_due && (phase_q == PH_DATA || phase_q == PH_FCS);
   assign want_byte = need && !stuff_due &&
                      (phase_q == PH_OPEN || (phase_q == PH_DATA && !last_q));
   assign in_ready  = bit_en && want_byte;

   always_comb begin
      ph_n       = phase_q;
      sh_n       = sh_q;
      rem_n      = rem_q;
      last_n     = last_q;
      fcs_hi_n   = fcs_hi_q;
      done_n     = 1'b0;
      adv        = 1'b0;
      bit_o      = 1'b0;
      go_idle    = 1'b0;
      ld         = 1'b0;
      ld_byte    = '0;
      sync_first = 1'b0;
      sync_step  = 1'b0;
      crc_clear  = 1'b0;
      if (bit_en) begin
         if (stuff_now) begin
            adv   = 1'b1;
            bit_o = 1'b0;
         end else if (need) begin
            unique case (phase_q)
               PH_IDLE: begin
                  if (in_valid) begin
                     crc_clear = 1'b1;
                     ld        = 1'b1;
                     if (SYNC_BYTES > 0) begin
                        ph_n       = PH_SYNC;
                        ld_byte    = SYNC_LSB_FIRST;
                        sync_first = 1'b1;
                     end else begin
                        ph_n    = PH_OPEN;
                        ld_byte = FLAG_PATTERN;
                     end
                  end
               end
               PH_SYNC: begin
                  ld = 1'b1;
                  if (sync_more) begin
                     ld_byte   = SYNC_LSB_FIRST;
                     sync_step = 1'b1;
                  end else begin
                     ph_n    = PH_OPEN;
                     ld_byte = FLAG_PATTERN;
                  end
               end
               PH_OPEN, PH_DATA: begin
                  if (phase_q == PH_DATA && last_q) begin
                     ph_n     = PH_FCS;
                     ld       = 1'b1;
                     ld_byte  = fcs_word[7:0];
                     fcs_hi_n = 1'b1;
                  end else if (in_valid) begin
                     ph_n    = PH_DATA;
                     ld      = 1'b1;
                     ld_byte = in_data;
                     last_n  = in_last;
                  end
               end
               PH_FCS: begin
                  ld = 1'b1;
                  if (fcs_hi_q) begin
                     ld_byte  = fcs_word[15:8];
                     fcs_hi_n = 1'b0;
                  end else begin
                     ph_n    = PH_CLOSE;
                     ld_byte = FLAG_PATTERN;
                  end
               end
               PH_CLOSE: begin
                  ph_n    = PH_IDLE;
                  go_idle = 1'b1;
                  done_n  = 1'b1;
                  last_n  = 1'b0;
               end
               default: begin
                  ph_n    = PH_IDLE;
                  go_idle = 1'b1;
               end
            endcase
            if (ld) begin
               adv   = 1'b1;
               bit_o = ld_byte[0];
               sh_n  = {1'b0, ld_byte[BYTE_W-1:1]};
               rem_n = REM_W'(BYTE_W - 1);
            end
         end else begin
            adv   = 1'b1;
            bit_o = sh_q[0];
            sh_n  = {1'b0, sh_q[BYTE_W-1:1]};
            rem_n = rem_q - REM_W'(1);
         end
      end
   end

   assign raw_mode = (ph_n == PH_SYNC);
   assign count_en = (ph_n == PH_DATA) || (ph_n == PH_FCS);
   assign crc_step = adv && !stuff_now && (ph_n == PH_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         sh_q     <= '0;
         rem_q    <= '0;
         last_q   <= 1'b0;
         fcs_hi_q <= 1'b0;
         done     <= 1'b0;
      end else begin
         phase_q  <= ph_n;
         sh_q     <= sh_n;
         rem_q    <= rem_n;
         last_q   <= last_n;
         fcs_hi_q <= fcs_hi_n;
         done     <= done_n;
      end
   end

   sdlc_fcs16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_fcs (
      .clk(clk), .rst_n(rst_n), .clear(crc_clear), .step(crc_step),
      .bit_in(bit_o), .fcs_word(fcs_word)
   );

   sdlc_zero_insert #(.RUN(STUFF_RUN)) u_zins (
      .clk(clk), .rst_n(rst_n), .adv(adv), .count_en(count_en),
      .bit_in(bit_o), .insert_due(stuff_due)
   );

   sdlc_line_coder #(.IDLE_LEVEL(IDLE_LEVEL)) u_line (
      .clk(clk), .rst_n(rst_n), .adv(adv), .raw_mode(raw_mode),
      .bit_in(bit_o), .go_idle(go_idle), .line(line_out)
   );

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> (line_out == IDLE_LEVEL)) else $error("idle line"); // R1
   AST_LINE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(line_out)) else $error("line moved without tick"); // R10
   AST_TAKE_ENTERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> (phase_q == PH_DATA)) else $error("accepted byte lost"); // R4
   AST_FCS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FCS) |-> $stable(fcs_word)) else $error("fcs moved while sent"); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9
   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase_q == PH_IDLE && line_out == IDLE_LEVEL)) else $error("done not at idle"); // R9
endmodule

// File: tb/sdlc_nrzi_tx_tb_top.sv
module sdlc_nrzi_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       in_ready, line_out, done;

   always #5 clk = ~clk;

   sdlc_nrzi_tx dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .line_out(line_out), .done(done)
   );

   int n_chk = 0;
   int n_bad = 0;

   // Scoreboard: kind 0 = sync/flag bit, 1 = first bit of payload byte,
   // 2 = inserted zero, 3 = check-sequence bit, 4 = other payload bit
   logic  lvl_q[$];
   int    kind_q[$];
   string tag_q[$];
   logic  mline;
   int    ones;
   bit    pend_done = 1'b0;
   bit    frame_over = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push_lvl(input logic l, input int k, input string t);
      lvl_q.push_back(l); kind_q.push_back(k); tag_q.push_back(t);
   endtask

   task automatic nrzi_bit(input logic b, input int k, input string t);
      if (!b) mline = ~mline;
      push_lvl(mline, k, t);
   endtask

   task automatic stuffed_bit(input logic b, input int k, input string t);
      nrzi_bit(b, k, t);
      if (b) ones++; else ones = 0;
      if (ones == 5) begin
         nrzi_bit(1'b0, 2, "R5");
         ones = 0;
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [7:0] p[$]);
      logic [15:0] c = 16'hFFFF;
      foreach (p[i]) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ p[i][b]) c = (c >> 1) ^ 16'h8408;
            else                c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic build_frame(input logic [7:0] p[$]);
      logic [15:0] fcs;
      logic [7:0]  tail[$];
      mline = 1'b1;
      for (int s = 0; s < 2; s++)
         for (int b = 7; b >= 0; b--) begin
            mline = 1'(8'h55 >> b);
            push_lvl(mline, 0, "R2");
         end
      for (int b = 0; b < 8; b++) nrzi_bit(1'(8'h7E >> b), 0, "R3");
      ones = 0;
      foreach (p[i])
         for (int b = 0; b < 8; b++) stuffed_bit(p[i][b], (b == 0) ? 1 : 4, "R6");
      fcs = ~ref_crc(p);
      for (int b = 0; b < 16; b++) stuffed_bit(fcs[b], 3, "R7");
      for (int b = 0; b < 8; b++) nrzi_bit(1'(8'h7E >> b), 0, "R3");
      // R7: residue of payload plus check sequence
      tail = p;
      tail.push_back(fcs[7:0]);
      tail.push_back(fcs[15:8]);
      chk(ref_crc(tail) == 16'hF0B8, "R7", "reference residue", int'(ref_crc(tail)), 16'hF0B8);
   endtask

   // Monitor: sample before the edge, compare after it
   initial begin
      logic en, rdy, line_pre, l;
      int k;
      string t;
      forever begin
         @(negedge clk); #3;
         en = bit_en; rdy = in_ready; line_pre = line_out;
         @(posedge clk); #3;
         if (rst_n) begin
            if (!en) begin
               chk(line_out === line_pre, "R10", "line without tick", int'(line_out), int'(line_pre));
            end else if (pend_done) begin
               chk(done === 1'b1, "R9", "done pulse", int'(done), 1);
               chk(line_out === 1'b1, "R9", "line after done", int'(line_out), 1);
               pend_done = 1'b0;
               frame_over = 1'b1;
            end else if (lvl_q.size() > 0) begin
               l = lvl_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
               chk(line_out === l, t, "line level", int'(line_out), int'(l));
               chk(rdy === (k == 1), (k == 1) ? "R4" : "R8", "in_ready", int'(rdy), int'(k == 1));
               chk(done === 1'b0, "R9", "early done", int'(done), 0);
               if (lvl_q.size() == 0) pend_done = 1'b1;
            end else begin
               chk(line_out === 1'b1 && done === 1'b0, "R1", "idle line", int'(line_out), 1);
            end
         end
      end
   end

   int cyc = 0;

   task automatic run_frame(input logic [7:0] p[$], input int div);
      int  idx = 0;
      bit  take;
      build_frame(p);
      frame_over = 1'b0;
      in_data  = p[0];
      in_last  = (p.size() == 1);
      in_valid = 1'b1;
      while (!frame_over) begin
         bit_en = ((cyc % div) == 0);
         cyc++;
         #3;
         take = in_valid && in_ready;
         @(negedge clk);
         if (take) begin
            idx++;
            if (idx < p.size()) begin
               in_data = p[idx];
               in_last = (idx == p.size() - 1);
            end else begin
               in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
            end
         end
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         bit_en = 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      chk(line_out === 1'b1 && done === 1'b0, "R1", "line in reset", int'(line_out), 1);
      @(negedge clk);
      rst_n = 1'b1;
      bit_en = 1'b1;
      #3;
      chk(in_ready === 1'b0, "R1", "ready after reset", int'(in_ready), 0);
      chk(line_out === 1'b1, "R1", "line after reset", int'(line_out), 1);
      @(negedge clk);
      idle_cycles(4);
      run_frame('{8'h11}, 1);
      idle_cycles(5);
      run_frame('{8'hFF, 8'hFF, 8'h00}, 3);
      idle_cycles(3);
      run_frame('{8'h7E, 8'h7E}, 1);
      idle_cycles(3);
      run_frame('{8'hF8, 8'h0F}, 2);
      idle_cycles(3);
      run_frame('{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB}, 1);
      idle_cycles(3);
      run_frame('{8'h3F, 8'hFC, 8'h1F, 8'hF0}, 4);
      idle_cycles(6);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule